// File: doc/BRIEF.md
# Attribute-Controlled Configuration Register Bank

This block holds the configuration registers of several logical devices in one physical bank. The host reaches it through two I/O ports. The address port holds a latched pointer that names a logical device, a function and a doubleword register. The data port then reads or writes the doubleword that the pointer names. Byte enables choose which byte lanes of a data write take part. Lane k carries bits 8k+7 down to 8k, so the lowest byte address holds the least significant byte.

Each bit of a register has its own access policy, and that policy decides what a write does to it. A bit can be read-only, read/write, write-only, write-1-to-clear, write-once or lockable. Hardware event inputs set the write-1-to-clear status bits. Reset loads every register with its default value and re-arms every write-once bit.

Both logical devices use the same layout. In the descriptions below, "the status byte" means bits 23:16 of register 1.
- Register 0 is a read-only identifier with the value 0x5A00_0000 plus the device number.
- Register 1 holds three fields. Bits 15:0 are read/write and reset to 0x1234. Bits 23:16 are the write-1-to-clear status byte and reset to 0. Bits 31:24 are write-once and reset to 0.
- Register 2 holds two fields. Bits 15:0 are lockable and reset to 0x00FF. Bits 31:16 are write-only.
- Register 3 holds the lock at bit 0, which is write-once and resets to 0. The other bits of register 3 read as 0.

Top module: `cfg_reg_bank`

## Requirements
- R1: After reset, the address port reads 0 and every register reads its default value as listed above.
- R2: A write to the address port (io_sel=0) updates the latched pointer only when io_be is 4'hF. Any narrower write leaves the pointer unchanged. Reads of the address port return the pointer.
- R3: The pointer is decoded as follows: bit 31 is the enable, bits 15:11 the device, bits 10:8 the function and bits 7:2 the register index. A data-port access is a miss when any of these holds: the enable is clear, the device is 2 or higher, the function is not 0, or the index is 4 or higher. A miss reads as 32'hFFFF_FFFF and ignores writes.
- R4: io_rvalid is high in exactly the cycle after a cycle with io_rd high, and io_rdata holds the read result in that cycle.
- R5: Writes to read-only bits have no effect.
- R6: On a data write, only bits in lanes whose io_be bit is 1 can change. Lane k carries bits 8k+7:8k.
- R7: On the status byte, writing 1 clears the bit and writing 0 leaves it unchanged. A high hw_event[8d+j] sets bit 16+j of device d. When a set and a clear of the same bit happen in the same cycle, the bit ends up set.
- R8: A write-once bit takes the first write that enables its lane after reset. Later writes to it are ignored.
- R9: Write-only bits always read as 0.
- R10: Lockable bits are writable while the lock bit (register 3, bit 0) is 0 and frozen once it is 1. The lock bit is write-once, so it stays 1 until reset.
- R11: A reset re-arms the write-once bits, so they take a new first write after it.
- R12: Writes to one logical device leave the registers of the other device unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | 0 selects the address port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data |
| hw_event | input | NDEV*EVW | Status set pulses, EVW bits per device |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid |

## Verification
The checker watches several rules on every cycle:
- the one-cycle read timing;
- that the address pointer holds on narrow writes and loads on full-width writes;
- that disabled accesses read as all ones;
- that an event sets the first status bit;
- that the lock stays set, and that the lockable field stays frozen once the lock is set;
- that write-only bits read as zero.

Some behaviours only the bench scenarios can show. These are the isolation of byte lanes, the clear-versus-set race on a status bit, write-once acceptance before and after a reset, isolation between the two devices, and misses caused by an unimplemented device or function.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef struct packed {
    logic [31:0] rw;
    logic [31:0] w1c;
    logic [31:0] wonce;
    logic [31:0] lck;
    logic [31:0] wo;
    logic [31:0] rstv;
  } reg_attr_t;

  localparam int EVT_REG  = 1;
  localparam int EVT_LSB  = 16;
  localparam int LOCK_REG = 3;
  localparam int LOCK_BIT = 0;
  localparam logic [31:0] ID_BASE = 32'h5A00_0000;

  function automatic reg_attr_t attr_of(input int unsigned dev, input int unsigned idx);
    reg_attr_t a;
    a = '0;
    case (idx)
      0: a.rstv = ID_BASE | 32'(dev);
      1: begin
        a.rw    = 32'h0000_FFFF;
        a.w1c   = 32'h00FF_0000;
        a.wonce = 32'hFF00_0000;
        a.rstv  = 32'h0000_1234;
      end
      2: begin
        a.lck  = 32'h0000_FFFF;
        a.wo   = 32'hFFFF_0000;
        a.rstv = 32'h0000_00FF;
      end
      3: a.wonce = 32'h0000_0001;
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [3:0]    be,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (wr && (be == 4'hF)) addr_q <= wdata;
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode #(
  parameter int NDEV = 2,
  parameter int NREG = 4,
  parameter int DW   = (NDEV > 1) ? $clog2(NDEV) : 1,
  parameter int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          en,
  input  logic [4:0]    dev_f,
  input  logic [2:0]    fn_f,
  input  logic [5:0]    reg_f,
  output logic          hit,
  output logic [DW-1:0] dev,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = en && (32'(dev_f) < NDEV) && (fn_f == 3'd0) && (32'(reg_f) < NREG);
    dev = DW'(dev_f);
    idx = IW'(reg_f);
  end
endmodule

// File: rtl/cfg_dev_regs.sv
module cfg_dev_regs
  import cfg_pkg::*;
#(
  parameter int DEV_ID = 0,
  parameter int NREG   = 4,
  parameter int EVW    = 8,
  parameter int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [IW-1:0]        idx,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  input  logic [EVW-1:0]       evt,
  output logic [NREG-1:0][31:0] rd
);
  logic [NREG-1:0][31:0] q, armed, nxt, armed_nxt;
  logic                  locked;
  reg_attr_t             at;
  logic [31:0]           m, wm, n;

  always_comb begin
    locked    = q[LOCK_REG][LOCK_BIT];
    nxt       = q;
    armed_nxt = armed;
    at = '0; m = '0; wm = '0; n = '0;
    for (int i = 0; i < NREG; i++) begin
      at = attr_of(DEV_ID, i);
      m  = (wr && (32'(idx) == i)) ? lane_mask(be) : 32'h0;
      wm = m & (at.rw | at.wo | (locked ? 32'h0 : at.lck) | (at.wonce & armed[i]));
      n  = (q[i] & ~wm) | (wdata & wm);
      n  = n & ~(m & wdata & at.w1c);
      if (i == EVT_REG) n = n | ((32'(evt) << EVT_LSB) & at.w1c);
      nxt[i]       = n;
      armed_nxt[i] = armed[i] & ~(m & at.wonce);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        q[i]     <= attr_of(DEV_ID, i).rstv;
        armed[i] <= '1;
      end
    end else begin
      q     <= nxt;
      armed <= armed_nxt;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_rd
      assign rd[g] = q[g] & ~attr_of(DEV_ID, g).wo;
    end
  endgenerate
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NDEV = 2,
  parameter int NREG = 4,
  parameter int EVW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                io_sel,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [3:0]          io_be,
  input  logic [31:0]         io_wdata,
  input  logic [NDEV*EVW-1:0] hw_event,
  output logic [31:0]         io_rdata,
  output logic                io_rvalid
);
  localparam int DW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0]                       addr_q;
  logic                              hit;
  logic [DW-1:0]                     dev_i;
  logic [IW-1:0]                     reg_i;
  logic [NDEV-1:0][NREG-1:0][31:0]   dev_q;

  cfg_addr_latch #(.AW(32)) u_lat (
    .clk(clk), .rst(rst), .wr(io_wr && !io_sel), .be(io_be),
    .wdata(io_wdata), .addr_q(addr_q)
  );

  cfg_decode #(.NDEV(NDEV), .NREG(NREG), .DW(DW), .IW(IW)) u_dec (
    .en(addr_q[31]), .dev_f(addr_q[15:11]), .fn_f(addr_q[10:8]),
    .reg_f(addr_q[7:2]), .hit(hit), .dev(dev_i), .idx(reg_i)
  );

  generate
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
      cfg_dev_regs #(.DEV_ID(d), .NREG(NREG), .EVW(EVW), .IW(IW)) u_dev (
        .clk(clk), .rst(rst),
        .wr(io_wr && io_sel && hit && (32'(dev_i) == d)),
        .idx(reg_i), .be(io_be), .wdata(io_wdata),
        .evt(hw_event[d*EVW +: EVW]), .rd(dev_q[d])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) begin
        if (!io_sel)  io_rdata <= addr_q;
        else if (hit) io_rdata <= dev_q[dev_i][reg_i];
        else          io_rdata <= '1;
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk #(
  parameter int NDEV = 2,
  parameter int NREG = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            io_sel,
  input logic                            io_wr,
  input logic                            io_rd,
  input logic [3:0]                      io_be,
  input logic [31:0]                     io_wdata,
  input logic                            evt0,
  input logic [31:0]                     io_rdata,
  input logic                            io_rvalid,
  input logic [31:0]                     addr_q,
  input logic [NDEV-1:0][NREG-1:0][31:0] dev_q
);
  // R4
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst) io_rd |=> io_rvalid);
  // R4
  no_spur_chk: assert property (@(posedge clk) disable iff (rst) !io_rd |=> !io_rvalid);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_sel && io_be != 4'hF) |=> $stable(addr_q));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_sel && io_be == 4'hF) |=> addr_q == $past(io_wdata));
  // R3
  miss_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_sel && !addr_q[31]) |=> io_rdata == 32'hFFFF_FFFF);
  // R7
  evt_set_chk: assert property (@(posedge clk) disable iff (rst) evt0 |=> dev_q[0][1][16]);
  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (rst) dev_q[0][3][0] |=> dev_q[0][3][0]);
  // R10
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    dev_q[0][3][0] |=> $stable(dev_q[0][2][15:0]));
  // R9
  wo_zero_chk: assert property (@(posedge clk) disable iff (rst) io_rvalid |-> dev_q[0][2][31:16] == 16'h0);
endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(.NDEV(NDEV), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
  .io_be(io_be), .io_wdata(io_wdata), .evt0(hw_event[0]), .io_rdata(io_rdata),
  .io_rvalid(io_rvalid), .addr_q(addr_q), .dev_q(dev_q)
);

// File: tb/sim_cfg_reg_bank.sv
`timescale 1ns/1ps
module sim_cfg_reg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0]  io_be = 4'h0;
  logic [31:0] io_wdata = '0;
  logic [15:0] hw_event = '0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  int          checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cfg_reg_bank u0 (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_be(io_be), .io_wdata(io_wdata), .hw_event(hw_event),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  // Monitor: pops expected read results as the design returns them (R4 timing).
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected rvalid actual=%h expected=none", io_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (io_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic s, input logic [31:0] e, input string t);
    @(negedge clk);
    io_sel = s; io_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic wr(input logic s, input logic [3:0] be, input logic [31:0] d,
                    input logic [15:0] ev);
    @(negedge clk);
    io_sel = s; io_wr = 1'b1; io_be = be; io_wdata = d; hw_event = ev;
    @(negedge clk);
    io_wr = 1'b0; io_be = 4'h0; hw_event = '0;
  endtask

  task automatic pick(input int dev, input int idx);
    wr(1'b0, 4'hF, 32'h8000_0000 | (32'(dev) << 11) | (32'(idx) << 2), 16'h0);
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk);
    hw_event = ev;
    @(negedge clk);
    hw_event = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    rd(1'b0, 32'h0, "R1 addr port after reset");
    pick(0, 0);
    rd(1'b1, 32'h5A00_0000, "R1 dev0 id");
    wr(1'b1, 4'hF, 32'hFFFF_FFFF, 16'h0);
    rd(1'b1, 32'h5A00_0000, "R5 read-only id unchanged");
    wr(1'b0, 4'h3, 32'h0, 16'h0);
    rd(1'b0, 32'h8000_0000, "R2 narrow addr write ignored");
    pick(0, 1);
    rd(1'b1, 32'h0000_1234, "R1 reg1 default");
    wr(1'b1, 4'h1, 32'hFFFF_FFAB, 16'h0);
    rd(1'b1, 32'h0000_12AB, "R6 lane0 only");
    wr(1'b1, 4'h2, 32'hFFFF_CDFF, 16'h0);
    rd(1'b1, 32'h0000_CDAB, "R6 lane1 only");
    pulse(16'h0004);
    rd(1'b1, 32'h0004_CDAB, "R7 event sets status");
    wr(1'b1, 4'h4, 32'h0000_0000, 16'h0);
    rd(1'b1, 32'h0004_CDAB, "R7 write 0 no effect");
    wr(1'b1, 4'h4, 32'h0004_0000, 16'h0);
    rd(1'b1, 32'h0000_CDAB, "R7 write 1 clears");
    wr(1'b1, 4'h4, 32'h0008_0000, 16'h0008);
    rd(1'b1, 32'h0008_CDAB, "R7 set wins over clear");
    wr(1'b1, 4'h8, 32'hAA00_0000, 16'h0);
    rd(1'b1, 32'hAA08_CDAB, "R8 first write-once write");
    wr(1'b1, 4'h8, 32'h5500_0000, 16'h0);
    rd(1'b1, 32'hAA08_CDAB, "R8 second write ignored");
    pick(0, 2);
    rd(1'b1, 32'h0000_00FF, "R1 reg2 default");
    wr(1'b1, 4'hF, 32'h1111_2222, 16'h0);
    rd(1'b1, 32'h0000_2222, "R9 write-only reads 0, R10 unlocked write");
    pick(0, 3);
    wr(1'b1, 4'h1, 32'h0000_0001, 16'h0);
    rd(1'b1, 32'h0000_0001, "R10 lock set");
    wr(1'b1, 4'hF, 32'h0000_0000, 16'h0);
    rd(1'b1, 32'h0000_0001, "R10 lock cannot clear");
    pick(0, 2);
    wr(1'b1, 4'hF, 32'hFFFF_3333, 16'h0);
    rd(1'b1, 32'h0000_2222, "R10 locked field frozen");
    pick(1, 1);
    rd(1'b1, 32'h0000_1234, "R12 dev1 reg1 untouched");
    pick(1, 0);
    rd(1'b1, 32'h5A00_0001, "R12 dev1 id");
    wr(1'b0, 4'hF, 32'h0000_0808, 16'h0);
    rd(1'b1, 32'hFFFF_FFFF, "R3 enable clear reads ones");
    wr(1'b1, 4'hF, 32'h1234_5678, 16'h0);
    pick(1, 2);
    rd(1'b1, 32'h0000_00FF, "R3 disabled write ignored");
    pick(5, 0);
    rd(1'b1, 32'hFFFF_FFFF, "R3 missing device reads ones");
    wr(1'b0, 4'hF, 32'h8000_0100, 16'h0);
    rd(1'b1, 32'hFFFF_FFFF, "R3 nonzero function reads ones");
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    rd(1'b0, 32'h0, "R1 addr port after second reset");
    pick(0, 1);
    rd(1'b1, 32'h0000_1234, "R11 reg1 default after reset");
    wr(1'b1, 4'h8, 32'h7700_0000, 16'h0);
    rd(1'b1, 32'h7700_1234, "R11 write-once re-armed");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule